// File: doc/BRIEF.md
# Buffered ECC SRAM Controller

This controller sits between a simple request/response bus and a single-port SRAM array. Each stored word carries a SECDED check code computed over the whole data word. A write that covers every byte lane is encoded and written in one array cycle.

A write that covers only some lanes is posted into a one-entry buffer. The buffer is drained in the background by a read-merge-write: the old word is read and corrected, the new lanes are merged in, the full word is re-encoded, and data and check bits go back in one array write. A read that targets the buffered word returns the merged value. A flag shows whether the buffer still holds unwritten data.

A control register holds the array power mode: off, retained or enabled. Before the mode may leave the enabled state, the buffer must be empty. While the array is not enabled, array accesses fail without touching it. Turning it off marks every word invalid until that word is written again in full.

Top module: `sram_ecc_wbuf`

## Requirements
- R1: A write with all byte enables set (to an array address while enabled) goes straight to the array without using the buffer. A later read returns the same data with rsp_err 0.
- R2: A write with some byte enables clear is posted. wb_empty reads 0 from the cycle after acceptance until the drain write completes. The drain takes two idle array cycles (read, then write), after which wb_empty reads 1.
- R3: After a partial write drains, a read returns the new bytes in enabled lanes and the previous bytes in all other lanes. Byte lane b is data bits 8b+7..8b.
- R4: A read accepted while the buffer holds a write to the same address returns the merged value (old word with the buffered lanes replaced).
- R5: The code is a SECDED Hamming code with 7 check bits for 32 data bits. Any single flipped bit of the 39-bit codeword is corrected and reported as correctable. Two flipped bits are reported as uncorrectable.
- R6: Mode encodings are OFF=2'b00, RETAINED=2'b01 and ENABLE=2'b10, and the reset mode is ENABLE. A register read (req_reg=1, req_write=0) returns the following fields, with all other bits 0:
  - bits 1:0: current mode
  - bit 2: buffer empty
  - bit 3: uncorrectable-error sticky flag
  - bits 5:4: requested mode
- R7: A register write changes the requested mode only when all byte enables are set and the data bits 1:0 are not 2'b11. Any other register write leaves both the requested and the current mode unchanged.
- R8: A request to leave ENABLE takes effect only after the buffer is empty. The current mode changes one cycle after wb_empty has read 1. A request to return to ENABLE takes effect one cycle after it is written.
- R9: While the current or requested mode is not ENABLE, array reads and writes respond with rsp_err 1, leave the array and the buffer unchanged, and do not post.
- R10: Entering OFF invalidates every word. Reads of an invalid word respond with rsp_err 1 and set the sticky ecc_fatal flag. A partial write does not make a word valid again; a full write does. The sticky flag stays set until reset.
- R11: Every accepted request (req_valid and req_ready both 1 at a clock edge) gives exactly one rsp_valid pulse two edges later. req_ready is 0 for array writes while the buffer is occupied, and for array reads during the drain write cycle.
- R12: After reset: wb_empty 1, pmode ENABLE, ecc_fatal 0, rsp_valid 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_reg | input | 1 | 1 = control/status register, 0 = array |
| req_addr | input | AW | Word address in the array |
| req_be | input | DW/8 | Byte lane enables for writes |
| req_wdata | input | DW | Write data |
| rsp_valid | output | 1 | Response strobe |
| rsp_rdata | output | DW | Read data or status word |
| rsp_err | output | 1 | Access refused or uncorrectable data |
| wb_empty | output | 1 | Posted-write buffer holds no data |
| pmode | output | 2 | Current array power mode |
| ecc_fatal | output | 1 | Sticky uncorrectable-error flag |

## Verification
The hardest state to reach is a read that arrives while the buffer still holds a posted write to the same word. The stimulus issues the read on the very cycle after the partial write is accepted. Reads take priority over the drain, so the read wins the port and is answered through the forwarding path.

Bit errors in stored words cannot be created from the ports. The code is therefore checked on the encoder and decoder instantiated on their own, with every single bit of the codeword flipped in turn and with a pair of bits flipped.

The mode hand-off is exercised by issuing the leave-enable request on the cycle right after a partial write is posted. The bench then watches the mode lag behind the buffer flag.

// File: rtl/sre_pkg.sv
package sre_pkg;
  typedef enum logic [1:0] {
    PM_OFF = 2'b00,
    PM_RET = 2'b01,
    PM_EN  = 2'b10
  } pmode_e;

  // smallest number of Hamming check bits for a data width
  function automatic int ecc_chk(input int dw);
    int r;
    r = 0;
    for (int p = 1; p < 16; p++)
      if (r == 0 && (1 << p) >= dw + p + 1) r = p;
    return r;
  endfunction
endpackage

// File: rtl/sre_ecc_enc.sv
module sre_ecc_enc #(
  parameter int DW = 32,
  localparam int P  = sre_pkg::ecc_chk(DW),
  localparam int CW = DW + P + 1
) (
  input  logic [DW-1:0] data,
  output logic [CW-1:0] code
);
  localparam int NP = DW + P;

  logic [NP:1]  pos;
  logic [P-1:0] par;

  always_comb begin
    int k;
    k   = 0;
    pos = '0;
    par = '0;
    for (int i = 1; i <= NP; i++)
      if ((i & (i - 1)) != 0) begin
        pos[i] = data[k];
        k++;
      end
    for (int i = 1; i <= NP; i++)
      for (int j = 0; j < P; j++)
        if (((i >> j) & 1) == 1) par[j] = par[j] ^ pos[i];
    code = {^{par, data}, par, data};
  end
endmodule

// File: rtl/sre_ecc_dec.sv
module sre_ecc_dec #(
  parameter int DW = 32,
  localparam int P  = sre_pkg::ecc_chk(DW),
  localparam int CW = DW + P + 1
) (
  input  logic [CW-1:0] code,
  output logic [DW-1:0] data,
  output logic          sbe,
  output logic          dbe
);
  localparam int NP = DW + P;

  logic [NP:1]  pos;
  logic [P-1:0] syn;
  logic         ov;
  int           sidx;

  always_comb begin
    int k;
    k   = 0;
    pos = '0;
    syn = '0;
    for (int j = 0; j < P; j++) pos[1 << j] = code[DW + j];
    for (int i = 1; i <= NP; i++)
      if ((i & (i - 1)) != 0) begin
        pos[i] = code[k];
        k++;
      end
    for (int i = 1; i <= NP; i++)
      for (int j = 0; j < P; j++)
        if (((i >> j) & 1) == 1) syn[j] = syn[j] ^ pos[i];
    ov   = ^code;
    sidx = int'(syn);
    sbe  = 1'b0;
    dbe  = 1'b0;
    if (ov) begin
      if (sidx <= NP) begin
        sbe = 1'b1;
        if (sidx != 0) pos[sidx] = ~pos[sidx];
      end else begin
        dbe = 1'b1;
      end
    end else if (sidx != 0) begin
      dbe = 1'b1;
    end
    k    = 0;
    data = '0;
    for (int i = 1; i <= NP; i++)
      if ((i & (i - 1)) != 0) begin
        data[k] = pos[i];
        k++;
      end
  end
endmodule

// File: rtl/sre_sram.sv
module sre_sram #(
  parameter int DEPTH = 256,
  parameter int W     = 39,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      rdata <= mem[addr];
    end
  end
endmodule

// File: rtl/sram_ecc_wbuf.sv
module sram_ecc_wbuf #(
  parameter int DW    = 32,
  parameter int DEPTH = 256,
  localparam int AW   = $clog2(DEPTH),
  localparam int BEW  = DW / 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic           req_reg,
  input  logic [AW-1:0]  req_addr,
  input  logic [BEW-1:0] req_be,
  input  logic [DW-1:0]  req_wdata,
  output logic           rsp_valid,
  output logic [DW-1:0]  rsp_rdata,
  output logic           rsp_err,
  output logic           wb_empty,
  output logic [1:0]     pmode,
  output logic           ecc_fatal
);
  import sre_pkg::*;

  localparam int P  = ecc_chk(DW);
  localparam int CW = DW + P + 1;

  // posted-write buffer
  logic           wb_valid, wb_phase;
  logic [AW-1:0]  wb_addr;
  logic [BEW-1:0] wb_be;
  logic [DW-1:0]  wb_data;

  pmode_e         pmode_q, mode_req;
  logic [DEPTH-1:0] vld;
  logic           ecc_fatal_q;

  // response pipeline
  logic           s1_valid, s1_isrd, s1_err;
  logic [DW-1:0]  s1_data;
  logic [AW-1:0]  rd_q_addr;

  // array port
  logic           mem_en, mem_we;
  logic [AW-1:0]  mem_addr;
  logic [CW-1:0]  mem_wcode, mem_q;
  logic [DW-1:0]  enc_in, dec_data, merged, rd_out, stat;
  logic           dec_sbe, dec_dbe;

  logic accept, gate_ok, arr_acc, arr_ok, rd_go, wr_full, wr_part;
  logic drain_rd, drain_wr, mode_wr, mode_go, rd_bad, drain_bad;

  assign req_ready = req_reg | ~wb_valid | (~wb_phase & ~req_write);
  assign accept    = req_valid & req_ready;
  assign gate_ok   = (pmode_q == PM_EN) && (mode_req == PM_EN);
  assign arr_acc   = accept & ~req_reg;
  assign arr_ok    = arr_acc & gate_ok;
  assign rd_go     = arr_ok & ~req_write;
  assign wr_full   = arr_ok & req_write & (&req_be);
  assign wr_part   = arr_ok & req_write & ~(&req_be);
  assign drain_rd  = wb_valid & ~wb_phase & ~rd_go;
  assign drain_wr  = wb_valid & wb_phase;

  assign mode_wr = accept & req_reg & req_write & (&req_be) & (req_wdata[1:0] != 2'b11);
  assign mode_go = (mode_req != pmode_q) && ((mode_req == PM_EN) || !wb_valid);

  assign mem_en   = rd_go | wr_full | drain_rd | drain_wr;
  assign mem_we   = wr_full | drain_wr;
  assign mem_addr = (drain_rd | drain_wr) ? wb_addr : req_addr;
  assign enc_in   = drain_wr ? merged : req_wdata;

  sre_ecc_enc #(.DW(DW)) u_enc (.data(enc_in), .code(mem_wcode));

  sre_sram #(.DEPTH(DEPTH), .W(CW)) u_mem (
    .clk(clk), .en(mem_en), .we(mem_we), .addr(mem_addr),
    .wdata(mem_wcode), .rdata(mem_q)
  );

  sre_ecc_dec #(.DW(DW)) u_dec (
    .code(mem_q), .data(dec_data), .sbe(dec_sbe), .dbe(dec_dbe)
  );

  // lane merge of the corrected old word with the buffered bytes
  always_comb begin
    for (int b = 0; b < BEW; b++)
      merged[8*b +: 8] = wb_be[b] ? wb_data[8*b +: 8] : dec_data[8*b +: 8];
  end

  assign rd_out    = (wb_valid && wb_addr == rd_q_addr) ? merged : dec_data;
  assign rd_bad    = dec_dbe | ~vld[rd_q_addr];
  assign drain_bad = dec_dbe | ~vld[wb_addr];

  always_comb begin
    stat      = '0;
    stat[1:0] = pmode_q;
    stat[2]   = ~wb_valid;
    stat[3]   = ecc_fatal_q;
    stat[5:4] = mode_req;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid    <= 1'b0;
      wb_phase    <= 1'b0;
      wb_addr     <= '0;
      wb_be       <= '0;
      wb_data     <= '0;
      pmode_q     <= PM_EN;
      mode_req    <= PM_EN;
      vld         <= '0;
      ecc_fatal_q <= 1'b0;
      s1_valid    <= 1'b0;
      s1_isrd     <= 1'b0;
      s1_err      <= 1'b0;
      s1_data     <= '0;
      rd_q_addr   <= '0;
      rsp_valid   <= 1'b0;
      rsp_err     <= 1'b0;
      rsp_rdata   <= '0;
    end else begin
      if (wr_part) begin
        wb_valid <= 1'b1;
        wb_phase <= 1'b0;
        wb_addr  <= req_addr;
        wb_be    <= req_be;
        wb_data  <= req_wdata;
      end else if (drain_rd) begin
        wb_phase <= 1'b1;
      end else if (drain_wr) begin
        wb_valid <= 1'b0;
        wb_phase <= 1'b0;
      end
      if (mode_wr) mode_req <= pmode_e'(req_wdata[1:0]);
      if (mode_go) begin
        pmode_q <= mode_req;
        if (mode_req == PM_OFF) vld <= '0;
      end
      if (wr_full) vld[req_addr] <= 1'b1;
      ecc_fatal_q <= ecc_fatal_q | (s1_isrd & rd_bad) | (drain_wr & drain_bad);
      s1_valid <= accept;
      s1_isrd  <= rd_go;
      s1_err   <= arr_acc & ~gate_ok;
      s1_data  <= (req_reg & ~req_write) ? stat : '0;
      if (rd_go) rd_q_addr <= req_addr;
      rsp_valid <= s1_valid;
      rsp_err   <= s1_isrd ? rd_bad : s1_err;
      rsp_rdata <= s1_isrd ? rd_out : s1_data;
    end
  end

  assign wb_empty  = ~wb_valid;
  assign pmode     = pmode_q;
  assign ecc_fatal = ecc_fatal_q;

  AST_FULL_BYPASS: assert property (@(posedge clk) disable iff (rst) wr_full |=> (wb_valid == $past(wb_valid))); // R1
  AST_POST_FLAG: assert property (@(posedge clk) disable iff (rst) wr_part |=> !wb_empty); // R2
  AST_DRAIN_ORDER: assert property (@(posedge clk) disable iff (rst) (mem_we && wb_phase) |-> $past(mem_en && !mem_we && wb_valid)); // R3
  AST_SEC_CLEAN: assert property (@(posedge clk) disable iff (rst) (s1_isrd && dec_sbe && !dec_dbe && vld[rd_q_addr]) |=> !rsp_err); // R5
  AST_LEAVE_WAIT: assert property (@(posedge clk) disable iff (rst) (pmode_q == PM_EN && wb_valid) |=> (pmode_q == PM_EN)); // R8
  AST_GATED_IDLE: assert property (@(posedge clk) disable iff (rst) (pmode_q != PM_EN) |-> !mem_en); // R9
  AST_OFF_INVALID: assert property (@(posedge clk) disable iff (rst) (pmode_q == PM_OFF) |-> (vld == '0)); // R10
  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (rst) accept |-> ##2 rsp_valid); // R11
endmodule

// File: tb/tb_sram_ecc_wbuf.sv
`timescale 1ns/1ps
module tb_sram_ecc_wbuf;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0, req_reg = 1'b0;
  logic        req_ready;
  logic [7:0]  req_addr = '0;
  logic [3:0]  req_be = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err, wb_empty, ecc_fatal;
  logic [31:0] rsp_rdata;
  logic [1:0]  pmode;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sram_ecc_wbuf dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_reg(req_reg), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .wb_empty(wb_empty),
    .pmode(pmode), .ecc_fatal(ecc_fatal)
  );

  // standalone codec for the bit-error cases
  logic [31:0] c_dat;
  logic [38:0] c_code, c_mask, c_bad;
  logic [31:0] c_out;
  logic        c_sbe, c_dbe;
  assign c_bad = c_code ^ c_mask;
  sre_ecc_enc #(.DW(32)) u_enc (.data(c_dat), .code(c_code));
  sre_ecc_dec #(.DW(32)) u_dec (.code(c_bad), .data(c_out), .sbe(c_sbe), .dbe(c_dbe));

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic r, input logic w, input logic [7:0] a,
                        input logic [3:0] be, input logic [31:0] d,
                        output logic [31:0] q, output logic e, output logic v);
    @(negedge clk);
    req_valid = 1'b1; req_reg = r; req_write = w;
    req_addr = a; req_be = be; req_wdata = d;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    q = rsp_rdata; e = rsp_err; v = rsp_valid;
  endtask

  // {write, be, addr, data, expected read}
  localparam logic [76:0] VEC [12] = '{
    {1'b1, 4'hF, 8'd10, 32'h11223344, 32'h0},
    {1'b1, 4'hF, 8'd11, 32'hA5A5A5A5, 32'h0},
    {1'b0, 4'h0, 8'd10, 32'h0,        32'h11223344},
    {1'b1, 4'h1, 8'd10, 32'hFFFFFF99, 32'h0},
    {1'b0, 4'h0, 8'd10, 32'h0,        32'h11223399},
    {1'b1, 4'hC, 8'd11, 32'hBEEF0000, 32'h0},
    {1'b0, 4'h0, 8'd11, 32'h0,        32'hBEEFA5A5},
    {1'b1, 4'h6, 8'd10, 32'h00CAFE00, 32'h0},
    {1'b0, 4'h0, 8'd10, 32'h0,        32'h11CAFE99},
    {1'b1, 4'hF, 8'd12, 32'h0,        32'h0},
    {1'b1, 4'h8, 8'd12, 32'h7F000000, 32'h0},
    {1'b0, 4'h0, 8'd12, 32'h0,        32'h7F000000}
  };

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] q;
    logic e, v;
    c_dat = '0; c_mask = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk("R12 wb_empty", 64'(wb_empty), 64'd1);
    chk("R12 pmode", 64'(pmode), 64'h2);
    chk("R12 ecc_fatal", 64'(ecc_fatal), 64'd0);
    chk("R12 rsp_valid", 64'(rsp_valid), 64'd0);
    do_req(1, 0, 0, 4'h0, 0, q, e, v);
    chk("R6 status after reset", 64'(q), 64'h26);

    // table: R1 full writes, R2 posting, R3 merge
    for (int i = 0; i < 12; i++) begin
      do_req(0, VEC[i][76], VEC[i][71:64], VEC[i][75:72], VEC[i][63:32], q, e, v);
      chk("R11 rsp_valid", 64'(v), 64'd1);
      chk("R1 R3 rsp_err", 64'(e), 64'd0);
      if (!VEC[i][76]) chk("R1 R3 read data", 64'(q), 64'(VEC[i][31:0]));
      else if (VEC[i][75:72] != 4'hF) chk("R2 wb_empty while posted", 64'(wb_empty), 64'd0);
    end
    repeat (3) @(negedge clk);
    chk("R2 wb_empty after drain", 64'(wb_empty), 64'd1);

    // R4 forwarding and R11 ready
    do_req(0, 1, 20, 4'hF, 32'h01020304, q, e, v);
    @(negedge clk);
    req_valid = 1; req_reg = 0; req_write = 1; req_addr = 20; req_be = 4'h2; req_wdata = 32'h0000AB00;
    @(posedge clk);
    @(negedge clk);
    req_write = 1; req_be = 4'hF; req_addr = 21; #1;
    chk("R11 ready low for write while buffered", 64'(req_ready), 64'd0);
    chk("R2 wb_empty after post", 64'(wb_empty), 64'd0);
    req_write = 0; req_be = 4'h0; req_addr = 20; #1;
    chk("R11 ready for read while buffered", 64'(req_ready), 64'd1);
    @(posedge clk);
    @(negedge clk); req_valid = 0;
    @(posedge clk);
    @(negedge clk);
    chk("R4 forwarded data", 64'(rsp_rdata), 64'h0102AB04);
    chk("R4 forwarded err", 64'(rsp_err), 64'd0);
    do_req(0, 0, 20, 4'h0, 0, q, e, v);
    chk("R3 merged after drain", 64'(q), 64'h0102AB04);

    // R7 ignored register writes
    do_req(1, 1, 0, 4'h7, 32'h1, q, e, v);
    do_req(1, 1, 0, 4'hF, 32'h3, q, e, v);
    do_req(1, 0, 0, 4'h0, 0, q, e, v);
    chk("R7 status unchanged", 64'(q), 64'h26);

    // R8 leaving enable waits for drain
    do_req(0, 1, 30, 4'hF, 32'h30303030, q, e, v);
    @(negedge clk);
    req_valid = 1; req_reg = 0; req_write = 1; req_addr = 30; req_be = 4'h1; req_wdata = 32'h5A;
    @(posedge clk);
    @(negedge clk);
    req_reg = 1; req_be = 4'hF; req_wdata = 32'h1;
    @(posedge clk);
    @(negedge clk); req_valid = 0; req_reg = 0;
    chk("R8 mode held while buffered", 64'(pmode), 64'h2);
    chk("R8 buffer still full", 64'(wb_empty), 64'd0);
    @(negedge clk);
    chk("R8 buffer empty first", 64'(wb_empty), 64'd1);
    chk("R8 mode not yet changed", 64'(pmode), 64'h2);
    @(negedge clk);
    chk("R8 mode retained", 64'(pmode), 64'h1);

    // R9 gated accesses
    do_req(0, 0, 10, 4'h0, 0, q, e, v);
    chk("R9 read refused", 64'(e), 64'd1);
    do_req(0, 1, 10, 4'hF, 32'hDEADBEEF, q, e, v);
    chk("R9 write refused", 64'(e), 64'd1);
    do_req(0, 1, 10, 4'h1, 32'h77, q, e, v);
    chk("R9 partial refused", 64'(e), 64'd1);
    chk("R9 no posting", 64'(wb_empty), 64'd1);
    do_req(1, 1, 0, 4'hF, 32'h2, q, e, v);
    chk("R8 back to enable", 64'(pmode), 64'h2);
    do_req(0, 0, 10, 4'h0, 0, q, e, v);
    chk("R9 array untouched", 64'(q), 64'h11CAFE99);
    chk("R9 read ok", 64'(e), 64'd0);
    do_req(0, 0, 30, 4'h0, 0, q, e, v);
    chk("R3 drained before retain", 64'(q), 64'h3030305A);

    // R10 off invalidates
    chk("R10 fatal clear before", 64'(ecc_fatal), 64'd0);
    do_req(1, 1, 0, 4'hF, 32'h0, q, e, v);
    chk("R10 mode off", 64'(pmode), 64'h0);
    do_req(1, 1, 0, 4'hF, 32'h2, q, e, v);
    do_req(0, 0, 11, 4'h0, 0, q, e, v);
    chk("R10 invalid read err", 64'(e), 64'd1);
    chk("R10 fatal set", 64'(ecc_fatal), 64'd1);
    do_req(0, 1, 11, 4'h1, 32'h55, q, e, v);
    repeat (3) @(negedge clk);
    do_req(0, 0, 11, 4'h0, 0, q, e, v);
    chk("R10 partial keeps invalid", 64'(e), 64'd1);
    do_req(0, 1, 11, 4'hF, 32'h12345678, q, e, v);
    do_req(0, 0, 11, 4'h0, 0, q, e, v);
    chk("R10 full write revalidates err", 64'(e), 64'd0);
    chk("R10 full write revalidates data", 64'(q), 64'h12345678);
    chk("R10 fatal sticky", 64'(ecc_fatal), 64'd1);

    // R5 codec
    c_dat = 32'hC0FFEE42; c_mask = '0; #1;
    chk("R5 clean data", 64'(c_out), 64'hC0FFEE42);
    chk("R5 clean flags", 64'({c_sbe, c_dbe}), 64'd0);
    for (int i = 0; i < 39; i++) begin
      c_mask = 39'd1 << i; #1;
      chk("R5 single corrected", 64'(c_out), 64'hC0FFEE42);
      chk("R5 single flags", 64'({c_sbe, c_dbe}), 64'h2);
    end
    c_mask = (39'd1 << 3) | (39'd1 << 20); #1;
    chk("R5 double detected", 64'({c_sbe, c_dbe}), 64'h1);
    c_mask = (39'd1 << 33) | (39'd1 << 7); #1;
    chk("R5 double with check bit", 64'({c_sbe, c_dbe}), 64'h1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule